// File: doc/BRIEF.md
# Programmable Burst Column Address Generator

This block sits in the column path of a synchronous graphics DRAM controller. It holds a small mode register and turns each column command into a stream of column addresses, one per clock, in the order the burst settings call for. A mode-register-set pulse captures the read latency, the burst length, the wrap order and a single-beat write option from a word on the mode input.

A column command supplies the start column and a read/write flag. The block then presents one address per cycle, flags the final beat, and stops by itself after a finite burst. A full-page burst runs until a terminate pulse arrives. A second column command in the middle of a burst cuts the old burst off and starts a new one.

For reads, a data-valid strobe follows each issued read address after exactly the programmed latency. Row activation, precharge timing, refresh and the storage array are handled elsewhere.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, col_valid_o, col_last_o and rd_valid_o are low. The mode register holds burst length 1, sequential order, latency 2 and single-beat writes off.
- R2: mrs_i loads the mode register from mode_i at the clock edge. The fields are mode_i[2:0] length code (0=1, 1=2, 2=4, 3=8, 7=full page, 4 to 6 act as 1), mode_i[3] order (0 sequential, 1 interleaved), mode_i[6:4] latency (3 selects 3, any other value selects 2) and mode_i[9] single-beat writes. Other bits are ignored. A burst uses the register contents at the edge that samples its column command.
- R3: At the edge that samples col_cmd_i, the block presents col_valid_o=1, col_addr_o=col_i and col_wr_o=col_wr_i, valid from that edge onward.
- R4: For a sequential burst of length L, beat k presents (start with its low log2(L) bits replaced by (start+k) mod L).
- R5: For an interleaved burst of length L, beat k presents start XOR k, with k below L.
- R6: col_last_o is high on beat L-1 of a finite burst. After that beat, col_valid_o falls unless a new column command is sampled.
- R7: A full-page burst steps through all 256 columns modulo 256, wraps, never raises col_last_o, and continues until it is terminated.
- R8: term_i sampled during a burst makes col_valid_o low from that edge onward. A column command sampled at the same edge takes priority.
- R9: A column command sampled during a burst discards the old burst and starts the new sequence at beat 0.
- R10: With single-beat writes on, a write burst is one beat long (col_last_o high on its first beat). Reads keep the programmed length.
- R11: rd_valid_o is high exactly CL cycles after each cycle that presents a read beat (col_valid_o=1, col_wr_o=0), where CL is the latency currently in the register. It stays low for write beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mrs_i | input | 1 | Mode register set strobe |
| mode_i | input | 10 | Mode word sampled with mrs_i |
| col_cmd_i | input | 1 | Column command strobe |
| col_wr_i | input | 1 | Column command is a write |
| col_i | input | 8 | Start column |
| term_i | input | 1 | Burst terminate |
| col_valid_o | output | 1 | A column address is presented |
| col_addr_o | output | 8 | Current column address |
| col_last_o | output | 1 | Current beat ends the burst |
| col_wr_o | output | 1 | Current burst is a write |
| rd_valid_o | output | 1 | Read data valid strobe |

## Verification
The address, last flag and write flag for a column command are due one edge after the command is sampled. They then advance once per edge. A terminate or a natural end shows as col_valid_o low one edge after the sampling edge. rd_valid_o is due CL edges after the cycle in which the read beat was presented. The bench drives inputs and samples outputs on the falling edge. Its model advances one step per rising edge and keeps a three-deep history of read beats, so every comparison is made in the cycle in which the result is due.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  typedef struct packed {
    logic [2:0] len_code;
    logic       il;
    logic       cl3;
    logic       wr_single;
  } burst_cfg_t;

  localparam logic [2:0] LEN_FULL = 3'd7;
endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
  import burst_col_pkg::*;
#(
  parameter int MODE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [MODE_W-1:0] mode_i,
  output burst_cfg_t        cfg_o
);
  burst_cfg_t cfg_d;

  always_comb begin
    cfg_d.len_code  = mode_i[2:0];
    cfg_d.il        = mode_i[3];
    cfg_d.cl3       = (mode_i[6:4] == 3'd3);
    cfg_d.wr_single = mode_i[9];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_o <= '0;
    else if (load_i) cfg_o <= cfg_d;
  end

  assert_mode_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(cfg_o));
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  burst_cfg_t       cfg_i,
  input  logic             cmd_i,
  input  logic             wr_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             term_i,
  output logic             valid_o,
  output logic [COL_W-1:0] addr_o,
  output logic             last_o,
  output logic             wr_o
);
  logic             act_q, full_q, il_q, wr_q;
  logic [COL_W-1:0] start_q, k_q, mask_q, len_mask, off;

  always_comb begin
    case (cfg_i.len_code)
      3'd1:     len_mask = COL_W'(1);
      3'd2:     len_mask = COL_W'(3);
      3'd3:     len_mask = COL_W'(7);
      LEN_FULL: len_mask = '1;
      default:  len_mask = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0; full_q <= 1'b0; il_q <= 1'b0; wr_q <= 1'b0;
      start_q <= '0; k_q <= '0; mask_q <= '0;
    end else if (cmd_i) begin
      act_q   <= 1'b1;
      start_q <= col_i;
      k_q     <= '0;
      wr_q    <= wr_i;
      il_q    <= cfg_i.il;
      if (wr_i && cfg_i.wr_single) begin
        mask_q <= '0;
        full_q <= 1'b0;
      end else begin
        mask_q <= len_mask;
        full_q <= (cfg_i.len_code == LEN_FULL);
      end
    end else if (act_q) begin
      if (term_i || last_o) act_q <= 1'b0;
      else k_q <= k_q + 1'b1;
    end
  end

  // wrap inside the burst-aligned window
  assign off     = il_q ? (start_q ^ k_q) : (start_q + k_q);
  assign addr_o  = (start_q & ~mask_q) | (off & mask_q);
  assign valid_o = act_q;
  assign last_o  = act_q && !full_q && (k_q == mask_q);
  assign wr_o    = wr_q;

  assert_start_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i |=> valid_o && addr_o == $past(col_i) && wr_o == $past(wr_i));
  assert_seq_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !last_o && !il_q && !cmd_i && !term_i |=>
      valid_o && addr_o == (($past(addr_o) & ~mask_q) | (($past(addr_o) + 1'b1) & mask_q)));
  assert_last_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && last_o && !cmd_i |=> !valid_o);
  assert_full_no_last_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && full_q |-> !last_o);
  assert_term_stop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_i && !cmd_i |=> !valid_o);
endmodule

// File: rtl/rd_valid_pipe.sv
module rd_valid_pipe #(
  parameter int MAX_CL = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic beat_i,
  input  logic cl3_i,
  output logic rd_valid_o
);
  logic [MAX_CL-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q[0] <= 1'b0;
    else sr_q[0] <= beat_i;
  end

  for (genvar i = 1; i < MAX_CL; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q[i] <= 1'b0;
      else sr_q[i] <= sr_q[i-1];
    end
  end

  assign rd_valid_o = cl3_i ? sr_q[2] : sr_q[1];

  assert_cl2_hit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cl3_i && $past(beat_i, 2) |-> rd_valid_o);
  assert_cl3_hit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cl3_i && $past(beat_i, 3) |-> rd_valid_o);
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int MODE_W = 10,
  parameter int MAX_CL = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mrs_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              col_cmd_i,
  input  logic              col_wr_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              term_i,
  output logic              col_valid_o,
  output logic [COL_W-1:0]  col_addr_o,
  output logic              col_last_o,
  output logic              col_wr_o,
  output logic              rd_valid_o
);
  burst_cfg_t cfg;
  logic       rd_beat;

  burst_mode_reg #(.MODE_W(MODE_W)) u_mode (
    .clk_i, .rst_ni, .load_i(mrs_i), .mode_i, .cfg_o(cfg)
  );

  burst_seq #(.COL_W(COL_W)) u_seq (
    .clk_i, .rst_ni, .cfg_i(cfg), .cmd_i(col_cmd_i), .wr_i(col_wr_i),
    .col_i, .term_i, .valid_o(col_valid_o), .addr_o(col_addr_o),
    .last_o(col_last_o), .wr_o(col_wr_o)
  );

  assign rd_beat = col_valid_o && !col_wr_o;

  rd_valid_pipe #(.MAX_CL(MAX_CL)) u_rdv (
    .clk_i, .rst_ni, .beat_i(rd_beat), .cl3_i(cfg.cl3), .rd_valid_o
  );

  assert_wr_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_cmd_i && col_wr_i && cfg.wr_single |=> col_last_o);
endmodule

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;
  logic clk = 0, rst_ni = 0;
  logic mrs_i = 0, col_cmd_i = 0, col_wr_i = 0, term_i = 0;
  logic [9:0] mode_i = '0;
  logic [7:0] col_i = '0;
  logic col_valid_o, col_last_o, col_wr_o, rd_valid_o;
  logic [7:0] col_addr_o;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  burst_col_gen u_dut (.clk_i(clk), .rst_ni, .mrs_i, .mode_i, .col_cmd_i, .col_wr_i,
    .col_i, .term_i, .col_valid_o, .col_addr_o, .col_last_o, .col_wr_o, .rd_valid_o);

  // bench model
  logic [2:0] md_len; bit md_il, md_ws; int md_cl;
  bit m_act, m_full, m_il, m_wr;
  logic [7:0] m_start, m_k, m_mask;
  bit h1, h2, h3;

  function automatic logic [7:0] len_mask(logic [2:0] code);
    case (code)
      3'd1: return 8'd1;
      3'd2: return 8'd3;
      3'd3: return 8'd7;
      3'd7: return 8'hFF;
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic [7:0] exp_addr();
    logic [7:0] off;
    off = m_il ? (m_start ^ m_k) : (m_start + m_k);
    return (m_start & ~m_mask) | (off & m_mask);
  endfunction

  function automatic logic [9:0] mword(logic [2:0] len, bit il, int cl, bit ws);
    return {ws, 2'b00, (cl == 3) ? 3'd3 : 3'd2, il, len};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(string vtag, bit cmd, bit wr, logic [7:0] col, bit term,
                     bit mrs, logic [9:0] mode);
    bit last, beat, rexp;
    @(negedge clk);
    last = m_act && !m_full && (m_k == m_mask);
    rexp = (md_cl == 3) ? h3 : h2;
    chk(vtag, col_valid_o, m_act);
    if (m_act) begin
      chk(m_il ? "R5" : (m_full ? "R7" : "R4"), col_addr_o, exp_addr());
      chk("R6", col_last_o, last);
      chk("R3", col_wr_o, m_wr);
    end
    chk("R11", rd_valid_o, rexp);
    // drive next edge
    col_cmd_i = cmd; col_wr_i = wr; col_i = col; term_i = term;
    mrs_i = mrs; mode_i = mode;
    // model edge
    beat = m_act && !m_wr;
    h3 = h2; h2 = h1; h1 = beat;
    if (cmd) begin
      m_act = 1; m_start = col; m_k = 0; m_wr = wr; m_il = md_il;
      if (wr && md_ws) begin m_mask = 0; m_full = 0; end
      else begin m_mask = len_mask(md_len); m_full = (md_len == 3'd7); end
    end else if (m_act) begin
      if (term || last) m_act = 0;
      else m_k = m_k + 1;
    end
    if (mrs) begin
      md_len = mode[2:0]; md_il = mode[3];
      md_cl = (mode[6:4] == 3'd3) ? 3 : 2; md_ws = mode[9];
    end
  endtask

  task automatic idle(string t, int n);
    for (int i = 0; i < n; i++) cyc(t, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic setmode(logic [9:0] w);
    cyc("R2", 0, 0, 0, 0, 1, w);
  endtask

  initial begin
    int r;
    void'($urandom(32'd4711));
    md_len = 0; md_il = 0; md_ws = 0; md_cl = 2;
    m_act = 0; m_full = 0; m_il = 0; m_wr = 0; m_start = 0; m_k = 0; m_mask = 0;
    h1 = 0; h2 = 0; h3 = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    chk("R1", col_valid_o, 0);
    chk("R1", col_last_o, 0);
    chk("R1", rd_valid_o, 0);
    // default mode: single-beat read
    cyc("R1", 1, 0, 8'h5C, 0, 0, 0);
    idle("R1", 5);
    // sequential 4, CL2
    setmode(mword(3'd2, 0, 2, 0));
    cyc("R3", 1, 0, 8'h0E, 0, 0, 0);
    idle("R6", 7);
    // interleaved 8, CL3
    setmode(mword(3'd3, 1, 3, 0));
    cyc("R3", 1, 0, 8'h35, 0, 0, 0);
    idle("R6", 12);
    // sequential 2 and 8
    setmode(mword(3'd1, 0, 2, 0));
    cyc("R3", 1, 0, 8'hFF, 0, 0, 0);
    idle("R6", 5);
    setmode(mword(3'd3, 0, 3, 0));
    cyc("R3", 1, 0, 8'hFD, 0, 0, 0);
    idle("R6", 12);
    // full page with wrap then terminate
    setmode(mword(3'd7, 0, 2, 0));
    cyc("R7", 1, 0, 8'hFA, 0, 0, 0);
    idle("R7", 262);
    cyc("R8", 0, 0, 0, 1, 0, 0);
    idle("R8", 5);
    // terminate vs command priority, truncation
    setmode(mword(3'd3, 1, 2, 0));
    cyc("R9", 1, 0, 8'h10, 0, 0, 0);
    idle("R9", 2);
    cyc("R9", 1, 1, 8'h83, 0, 0, 0);
    idle("R9", 2);
    cyc("R8", 1, 0, 8'h44, 1, 0, 0);
    idle("R8", 3);
    cyc("R8", 0, 0, 0, 1, 0, 0);
    idle("R8", 5);
    // single-beat writes
    setmode(mword(3'd2, 0, 3, 1));
    cyc("R10", 1, 1, 8'h21, 0, 0, 0);
    idle("R10", 3);
    cyc("R10", 1, 0, 8'h21, 0, 0, 0);
    idle("R10", 8);
    // ignored mode bits, reserved length code
    setmode(10'b0110000100);
    cyc("R2", 1, 0, 8'h77, 0, 0, 0);
    idle("R2", 5);
    // random
    for (int i = 0; i < 4000; i++) begin
      bit cmd, term, mrs;
      r = $urandom_range(0, 99);
      cmd = (r < 15);
      term = (r >= 94);
      mrs = !m_act && r >= 15 && r < 20;
      cyc("R9", cmd, $urandom_range(0, 1), 8'($urandom), term, mrs, 10'($urandom));
    end
    idle("R6", 4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule